// File: doc/BRIEF.md
# Prefetch Burst Data Serializer

This block sits between a wide core-side data word and a narrow double-data-rate pin interface. On the transmit side it takes one word of `BEATS` lanes of `LANE_W` bits in a single valid/ready handshake. It then plays that word out as a burst of narrow beats. To stay synthesizable without a real dual-edge output register, each clock presents two beats at once: one on a rise lane and one on a fall lane. A strobe-enable window opens one clock before the first data beat, and that clock is the preamble.

Each burst runs either full length (eight beats, four clocks of data) or chopped (four beats, two clocks of data). In chopped mode the upper half of the word never reaches the pins. The receive side is the mirror image. It gathers rise and fall lane pairs into a wide word and pulses a done flag once the programmed number of beats has arrived.

The transmit machine has three states. `TX_IDLE` waits for a word. `TX_PRE` drives the preamble. `TX_DATA` plays the beat pairs. Its transitions are:
- idle to preamble on an accepted word;
- preamble to data unconditionally;
- data to itself while pairs remain;
- data to idle after the last pair.

The receive machine has two states. `RX_WAIT` waits for the first pair. `RX_FILL` collects the rest. Its transitions are:
- wait to fill on a first pair that is not the last;
- fill to itself while pairs remain;
- fill to wait on the last pair.

Top module: `burst_serdes`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_ready` is 1 and `strobe_en`, `dq_valid` and `rx_done` are 0.
- R2: When `tx_valid` and `tx_ready` are both 1 at a rising clock edge, the following cycle is the preamble: `strobe_en` is 1, `dq_valid` is 0 and `tx_ready` is 0.
- R3: In data cycle p (p counted from 0 after the preamble), `dq_rise` carries bits [2p*LANE_W +: LANE_W] of the accepted word and `dq_fall` carries bits [(2p+1)*LANE_W +: LANE_W]. Beat k is therefore bits [k*LANE_W +: LANE_W], lowest beat first, with even beats on the rise lane and odd beats on the fall lane.
- R4: With `tx_chop` = 0 at acceptance there are exactly four data cycles, and with `tx_chop` = 1 there are exactly two. `strobe_en` is 1 in every data cycle.
- R5: In chopped mode, bits [WORD_W-1:WORD_W/2] of the transmit word never appear on the lanes. The word assembled on the receive side has those bits at 0.
- R6: The cycle after the last data cycle has `tx_ready` = 1 and `strobe_en` = 0. A word offered in that cycle is accepted, so bursts run back to back with one idle cycle between them.
- R7: Changes to `tx_valid`, `tx_word` and `tx_chop` while `tx_ready` is 0 have no effect on the burst in progress.
- R8: When `rx_done` is 1, `rx_word` equals the word whose beats were delivered on `rx_rise`/`rx_fall` during the `rx_valid` cycles of that burst. The burst length is taken from `rx_chop` in the first pair's cycle.
- R9: `rx_done` is a single-cycle pulse. It rises in the cycle right after the last beat pair is received.
- R10: `dq_rise` and `dq_fall` are 0 whenever `dq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit side can accept a word |
| tx_word | input | LANE_W*BEATS | Wide word to serialize |
| tx_chop | input | 1 | 1 selects a four-beat chopped burst |
| strobe_en | output | 1 | Strobe window, preamble plus data cycles |
| dq_valid | output | 1 | Lanes carry data beats this cycle |
| dq_rise | output | LANE_W | Even beat of the current pair |
| dq_fall | output | LANE_W | Odd beat of the current pair |
| rx_valid | input | 1 | Receive lanes carry a beat pair |
| rx_rise | input | LANE_W | Received even beat |
| rx_fall | input | LANE_W | Received odd beat |
| rx_chop | input | 1 | 1 selects a four-beat burst, sampled at the first pair |
| rx_word | output | LANE_W*BEATS | Assembled wide word |
| rx_done | output | 1 | One-cycle pulse, assembly complete |

## Verification
The bench loops the transmit lanes straight back into the receive lanes. It sweeps a series of words whose lanes are computed from the burst index and the lane position, so any swap of rise and fall, off-by-one pair selection or reversed order gives a distinct mismatch. Full and chopped bursts are interleaved, which separates the two end-of-burst points and shows whether stale upper bits leak into a chopped word. Some bursts keep `tx_valid` high with an inverted word and flipped mode during the burst, which exposes any reload while busy. Idle gaps alternate with back-to-back starts, which separates a correct idle return from one that stalls or skips the idle cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_PRE  = 2'd1,
        TX_DATA = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_FILL = 1'b1
    } rx_state_e;
endpackage

// File: rtl/beat_tx.sv
module beat_tx
    import burst_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int BEATS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANE_W*BEATS-1:0]  in_word,
    input  logic                     in_chop,
    output logic                     strobe_en,
    output logic                     lane_valid,
    output logic [LANE_W-1:0]        lane_rise,
    output logic [LANE_W-1:0]        lane_fall
);
    localparam int PAIRS      = BEATS / 2;
    localparam int PW         = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PW-1:0] FULL_LAST = PW'(PAIRS - 1);
    localparam logic [PW-1:0] CHOP_LAST = PW'(PAIRS / 2 - 1);

    tx_state_e                      state_q, state_d;
    logic [PW-1:0]                  pair_q, pair_d;
    logic                           chop_q, chop_d;
    logic [BEATS-1:0][LANE_W-1:0]   word_q, word_d, load_word;
    logic [PW-1:0]                  last_pair;

    // chopped bursts drop the upper half at load time
    for (genvar g = 0; g < BEATS; g++) begin : g_load
        if (g >= BEATS / 2) begin : g_upper
            assign load_word[g] = in_chop ? '0 : in_word[g*LANE_W +: LANE_W];
        end else begin : g_lower
            assign load_word[g] = in_word[g*LANE_W +: LANE_W];
        end
    end

    assign last_pair = chop_q ? CHOP_LAST : FULL_LAST;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            pair_q  <= '0;
            chop_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            pair_q  <= pair_d;
            chop_q  <= chop_d;
            word_q  <= word_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        pair_d  = pair_q;
        chop_d  = chop_q;
        word_d  = word_q;
        unique case (state_q)
            TX_IDLE: begin
                if (in_valid) begin
                    state_d = TX_PRE;
                    chop_d  = in_chop;
                    word_d  = load_word;
                end
            end
            TX_PRE: begin
                state_d = TX_DATA;
                pair_d  = '0;
            end
            TX_DATA: begin
                if (pair_q == last_pair) begin
                    state_d = TX_IDLE;
                    pair_d  = '0;
                end else begin
                    pair_d = pair_q + 1'b1;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        strobe_en  = 1'b0;
        lane_valid = 1'b0;
        lane_rise  = '0;
        lane_fall  = '0;
        unique case (state_q)
            TX_IDLE: in_ready = 1'b1;
            TX_PRE:  strobe_en = 1'b1;
            TX_DATA: begin
                strobe_en  = 1'b1;
                lane_valid = 1'b1;
                lane_rise  = word_q[{pair_q, 1'b0}];
                lane_fall  = word_q[{pair_q, 1'b1}];
            end
            default: in_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/beat_rx.sv
module beat_rx
    import burst_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int BEATS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     beat_valid,
    input  logic [LANE_W-1:0]        beat_rise,
    input  logic [LANE_W-1:0]        beat_fall,
    input  logic                     beat_chop,
    output logic [LANE_W*BEATS-1:0]  out_word,
    output logic                     out_done
);
    localparam int PAIRS      = BEATS / 2;
    localparam int PW         = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PW-1:0] FULL_LAST = PW'(PAIRS - 1);
    localparam logic [PW-1:0] CHOP_LAST = PW'(PAIRS / 2 - 1);

    rx_state_e                      state_q, state_d;
    logic [PW-1:0]                  cnt_q, cnt_d;
    logic                           chop_q, chop_d;
    logic                           done_q, done_d;
    logic [BEATS-1:0][LANE_W-1:0]   word_q, word_d, base;
    logic                           eff_chop;
    logic [PW-1:0]                  last_pair;

    assign eff_chop  = (state_q == RX_WAIT) ? beat_chop : chop_q;
    assign last_pair = eff_chop ? CHOP_LAST : FULL_LAST;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_WAIT;
            cnt_q   <= '0;
            chop_q  <= 1'b0;
            done_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            chop_q  <= chop_d;
            done_q  <= done_d;
            word_q  <= word_d;
        end
    end

    // transitions and gathering
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        chop_d  = chop_q;
        done_d  = 1'b0;
        word_d  = word_q;
        base    = (state_q == RX_WAIT) ? '0 : word_q;
        if (beat_valid) begin
            base[{cnt_q, 1'b0}] = beat_rise;
            base[{cnt_q, 1'b1}] = beat_fall;
            word_d = base;
            unique case (state_q)
                RX_WAIT: chop_d = beat_chop;
                RX_FILL: chop_d = chop_q;
                default: chop_d = chop_q;
            endcase
            if (cnt_q == last_pair) begin
                state_d = RX_WAIT;
                cnt_d   = '0;
                done_d  = 1'b1;
            end else begin
                state_d = RX_FILL;
                cnt_d   = cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_word = word_q;
        out_done = done_q;
    end
endmodule

// File: rtl/burst_serdes.sv
module burst_serdes #(
    parameter int LANE_W = 16,
    parameter int BEATS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_valid,
    output logic                     tx_ready,
    input  logic [LANE_W*BEATS-1:0]  tx_word,
    input  logic                     tx_chop,
    output logic                     strobe_en,
    output logic                     dq_valid,
    output logic [LANE_W-1:0]        dq_rise,
    output logic [LANE_W-1:0]        dq_fall,
    input  logic                     rx_valid,
    input  logic [LANE_W-1:0]        rx_rise,
    input  logic [LANE_W-1:0]        rx_fall,
    input  logic                     rx_chop,
    output logic [LANE_W*BEATS-1:0]  rx_word,
    output logic                     rx_done
);
    beat_tx #(.LANE_W(LANE_W), .BEATS(BEATS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid),
        .in_ready   (tx_ready),
        .in_word    (tx_word),
        .in_chop    (tx_chop),
        .strobe_en  (strobe_en),
        .lane_valid (dq_valid),
        .lane_rise  (dq_rise),
        .lane_fall  (dq_fall)
    );

    beat_rx #(.LANE_W(LANE_W), .BEATS(BEATS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (rx_valid),
        .beat_rise  (rx_rise),
        .beat_fall  (rx_fall),
        .beat_chop  (rx_chop),
        .out_word   (rx_word),
        .out_done   (rx_done)
    );
endmodule

// File: rtl/burst_serdes_chk.sv
module burst_serdes_chk #(
    parameter int LANE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              strobe_en,
    input logic              dq_valid,
    input logic [LANE_W-1:0] dq_rise,
    input logic [LANE_W-1:0] dq_fall,
    input logic              rx_done
);
    a_r2_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (strobe_en && !dq_valid && !tx_ready));

    a_r4_strobe_covers_data: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> strobe_en);

    a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!strobe_en && !dq_valid));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    a_r10_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_rise == '0 && dq_fall == '0));
endmodule

bind burst_serdes burst_serdes_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .strobe_en (strobe_en),
    .dq_valid  (dq_valid),
    .dq_rise   (dq_rise),
    .dq_fall   (dq_fall),
    .rx_done   (rx_done)
);

// File: tb/sim_burst_serdes.sv
module sim_burst_serdes;
    localparam int LW = 16;
    localparam int NB = 8;
    localparam int WW = LW * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [WW-1:0] tx_word = '0;
    logic          tx_chop = 1'b0;
    logic          strobe_en, dq_valid, rx_done;
    logic [LW-1:0] dq_rise, dq_fall;
    logic [WW-1:0] rx_word;
    logic          rx_chop_q = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_serdes #(.LANE_W(LW), .BEATS(NB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word), .tx_chop(tx_chop),
        .strobe_en(strobe_en), .dq_valid(dq_valid), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .rx_valid(dq_valid), .rx_rise(dq_rise), .rx_fall(dq_fall), .rx_chop(rx_chop_q),
        .rx_word(rx_word), .rx_done(rx_done)
    );

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mk_word(input int b);
        logic [WW-1:0] w;
        for (int k = 0; k < NB; k++)
            w[k*LW +: LW] = LW'((b * 37 + k * 11 + 1) * 257) ^ LW'(b << 4) ^ LW'(k << 12);
        return w;
    endfunction

    // starts at a negedge where the block should be idle
    task automatic burst(input logic [WW-1:0] w, input bit chop, input bit junk);
        int pairs;
        logic [WW-1:0] exp;
        pairs = chop ? 2 : 4;
        exp = chop ? {{(WW/2){1'b0}}, w[WW/2-1:0]} : w;
        chk(tx_ready == 1'b1, "R6 ready before start", WW'(tx_ready), WW'(1));
        tx_valid = 1'b1; tx_word = w; tx_chop = chop; rx_chop_q = chop;
        @(negedge clk);
        if (junk) begin tx_word = ~w; tx_chop = ~chop; end
        else tx_valid = 1'b0;
        chk(strobe_en && !dq_valid && !tx_ready, "R2 preamble",
            WW'({strobe_en, dq_valid, tx_ready}), WW'(3'b100));
        chk(dq_rise == '0 && dq_fall == '0, "R10 lanes quiet in preamble",
            WW'({dq_rise, dq_fall}), '0);
        chk(rx_done == 1'b0, "R9 done single pulse", WW'(rx_done), '0);
        for (int p = 0; p < pairs; p++) begin
            @(negedge clk);
            chk(dq_valid && strobe_en, "R4 data cycle", WW'({dq_valid, strobe_en}), WW'(2'b11));
            chk(dq_rise == w[2*p*LW +: LW], junk ? "R7 R3 rise lane" : "R3 rise lane",
                WW'(dq_rise), WW'(w[2*p*LW +: LW]));
            chk(dq_fall == w[(2*p+1)*LW +: LW], junk ? "R7 R3 fall lane" : "R3 fall lane",
                WW'(dq_fall), WW'(w[(2*p+1)*LW +: LW]));
            if (p == pairs - 1) tx_valid = 1'b0;
        end
        @(negedge clk);
        chk(tx_ready && !strobe_en && !dq_valid, chop ? "R4 R6 chop burst end" : "R4 R6 full burst end",
            WW'({tx_ready, strobe_en, dq_valid}), WW'(3'b100));
        chk(dq_rise == '0 && dq_fall == '0, "R10 lanes quiet in idle", WW'({dq_rise, dq_fall}), '0);
        chk(rx_done == 1'b1, "R9 done after last pair", WW'(rx_done), WW'(1));
        chk(rx_word == exp, chop ? "R5 R8 chopped assembly" : "R8 full assembly", rx_word, exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk(tx_ready && !strobe_en && !dq_valid && !rx_done, "R1 reset state",
            WW'({tx_ready, strobe_en, dq_valid, rx_done}), WW'(4'b1000));
        @(negedge clk);
        rst_n = 1'b1;
        chk(tx_ready && !strobe_en && !dq_valid && !rx_done, "R1 after reset",
            WW'({tx_ready, strobe_en, dq_valid, rx_done}), WW'(4'b1000));
        for (int b = 0; b < 30; b++) begin
            burst(mk_word(b), (b % 3) == 1, (b % 4) == 3);
            if ((b % 5) == 4) begin
                for (int g = 0; g < 2; g++) begin
                    @(negedge clk);
                    chk(tx_ready && !strobe_en && !rx_done, "R6 idle holds",
                        WW'({tx_ready, strobe_en, rx_done}), WW'(3'b100));
                end
            end
        end
        // full burst then chopped: stale upper bits must be cleared
        burst({WW{1'b1}}, 1'b0, 1'b0);
        burst({WW{1'b1}}, 1'b1, 1'b0);
        @(negedge clk);
        chk(rx_done == 1'b0, "R9 done single pulse", WW'(rx_done), '0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule